// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state for up to sixteen independent address translation contexts in an I/O translation unit. Each context owns a control word, a translation configuration word, a two-word table base, a memory attribute word, a fault status word and a two-word fault address. Software reaches all of them through one 32-bit register port. The upper address bits select the context and the low bits select the register.

The translation core sits on the other side and is not part of this block. It receives each context's enable and pending-invalidation request. It acknowledges an invalidation with a per-context done pulse. It reports faults as a context index, a fault type and a 64-bit faulting address. The block latches the first fault of each context and holds it until software clears it. It also raises one level-sensitive interrupt that combines every context whose interrupts are enabled and whose fault status is not empty.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: A read request (req_i=1, we_i=0) returns its data on rdata_o with rvalid_o=1 in the cycle after the request. rvalid_o is 0 in every other cycle.
- R2: Context c occupies the 0x40-byte window at c×0x40 for c<8 and at 0x800+(c−8)×0x40 for c≥8. Within a window the registers sit at these offsets: control 0x00, config 0x08, table base low 0x10, table base high 0x14, fault status 0x20, attribute 0x28, fault address low 0x30, fault address high 0x34. Any other address reads 0, and a write to it changes no register.
- R3: Control bit 0 drives ctx_en_o[c] and bit 2 enables that context's interrupt. Writing 0 to the control register clears both.
- R4: Writing control bit 1 as 1 sets flush_req_o[c], and bit 1 reads back as 1. The bit stays set, even when control is later written with bit 1 = 0, until a flush_done_i[c] pulse clears it.
- R5: A fault (fault_valid_i=1) for a context whose status is 0 latches fault_type_i into status and fault_addr_i into the address pair, low word at 0x30 and high word at 0x34. Status bit 0 is translation fault, bit 1 page fault, bit 2 walk abort and bit 4 multiple hit. Bit 3 is never stored.
- R6: While a context's status is nonzero, further faults for that context change neither the status nor the address.
- R7: A write to status leaves status AND the written value. Writing back the value just read keeps every flag set. When the result is 0, both fault address words read 0.
- R8: irq_o is 1 exactly when some context has nonzero status and its interrupt enable set. It drops as soon as the status is cleared or the enable is removed.
- R9: The config, table base low, table base high and attribute registers store full 32-bit values, separately for each context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| fault_valid_i | input | 1 | Fault report strobe |
| fault_ctx_i | input | 4 | Faulting context index |
| fault_type_i | input | 5 | Fault type flags |
| fault_addr_i | input | 64 | Faulting address |
| flush_done_i | input | 16 | Per-context invalidation complete pulse |
| flush_req_o | output | 16 | Per-context invalidation pending |
| ctx_en_o | output | 16 | Per-context translation enable |
| irq_o | output | 1 | Combined fault interrupt |

## Verification
The assertions check the following properties on every cycle, all at the ports:
- read timing;
- the flush request holds until done and falls on a done pulse;
- the interrupt and the enables can change only through a fault report or a register write.

The bench scenarios cover the behaviour that depends on data values:
- address decode across the relocated upper window and the unmapped holes;
- the first-fault-wins latching;
- AND-style clearing of the status, and the address words reading 0 after the clear;
- the interrupt dependence on the enable bit.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_CFG, RS_TLO, RS_THI, RS_STAT, RS_ATTR, RS_FALO, RS_FAHI
  } reg_sel_e;

  localparam int unsigned FLT_W = 5;
  localparam logic [FLT_W-1:0] FLT_MASK = 5'b10111;

  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      32'h00:  return RS_CTRL;
      32'h08:  return RS_CFG;
      32'h10:  return RS_TLO;
      32'h14:  return RS_THI;
      32'h20:  return RS_STAT;
      32'h28:  return RS_ATTR;
      32'h30:  return RS_FALO;
      32'h34:  return RS_FAHI;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/xlat_addr_dec.sv
module xlat_addr_dec
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int ADDR_W  = 12,
  parameter int STRIDE  = 'h40,
  parameter int SPLIT   = 8,
  parameter int HI_WIN  = 'h800
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_CTX-1:0] hit_o,
  output reg_sel_e           sel_o
);
  localparam int OFF_W = $clog2(STRIDE);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_hit
    // upper contexts live in a relocated window
    localparam logic [ADDR_W-1:0] CB =
      ADDR_W'((c < SPLIT) ? c * STRIDE : HI_WIN + (c - SPLIT) * STRIDE);
    assign hit_o[c] = (addr_i[ADDR_W-1:OFF_W] == CB[ADDR_W-1:OFF_W]);
  end

  assign sel_o = decode_off(32'(addr_i[OFF_W-1:0]));
endmodule

// File: rtl/xlat_ctx_slot.sv
module xlat_ctx_slot
  import xlat_ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             flt_i,
  input  logic [FLT_W-1:0] flt_type_i,
  input  logic [63:0]      flt_addr_i,
  input  logic             flush_done_i,
  output logic             en_o,
  output logic             flush_o,
  output logic             irq_o
);
  logic             en_q, ie_q, fl_q;
  logic [31:0]      cfg_q, tlo_q, thi_q, attr_q;
  logic [FLT_W-1:0] st_q, st_and;
  logic [63:0]      fa_q;
  logic [FLT_W-1:0] flt_bits;
  logic             cap;

  assign flt_bits = flt_type_i & FLT_MASK;
  assign cap      = flt_i && (st_q == '0) && (flt_bits != '0);
  assign st_and   = st_q & wdata_i[FLT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ie_q <= 1'b0; fl_q <= 1'b0;
      cfg_q <= '0; tlo_q <= '0; thi_q <= '0; attr_q <= '0;
      st_q <= '0; fa_q <= '0;
    end else begin
      if (flush_done_i) fl_q <= 1'b0;
      if (wr_i) begin
        unique case (sel_i)
          RS_CTRL: begin
            en_q <= wdata_i[0];
            ie_q <= wdata_i[2];
            if (wdata_i[1]) fl_q <= 1'b1;  // only hardware can drop it
          end
          RS_CFG:  cfg_q  <= wdata_i;
          RS_TLO:  tlo_q  <= wdata_i;
          RS_THI:  thi_q  <= wdata_i;
          RS_ATTR: attr_q <= wdata_i;
          default: ;
        endcase
      end
      if (cap) begin
        st_q <= flt_bits;
        fa_q <= flt_addr_i;
      end else if (wr_i && sel_i == RS_STAT) begin
        st_q <= st_and;
        if (st_and == '0) fa_q <= '0;
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      RS_CTRL: rdata_o = {29'd0, ie_q, fl_q, en_q};
      RS_CFG:  rdata_o = cfg_q;
      RS_TLO:  rdata_o = tlo_q;
      RS_THI:  rdata_o = thi_q;
      RS_STAT: rdata_o = {{(32-FLT_W){1'b0}}, st_q};
      RS_ATTR: rdata_o = attr_q;
      RS_FALO: rdata_o = fa_q[31:0];
      RS_FAHI: rdata_o = fa_q[63:32];
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign flush_o = fl_q;
  assign irq_o   = ie_q && (st_q != '0);
endmodule

// File: rtl/xlat_collect.sv
module xlat_collect #(
  parameter int NUM_CTX = 16
) (
  input  logic [NUM_CTX-1:0]       hit_i,
  input  logic [NUM_CTX-1:0][31:0] rdata_i,
  input  logic [NUM_CTX-1:0]       irq_i,
  output logic [31:0]              rdata_o,
  output logic                     irq_o
);
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (hit_i[c]) rdata_o = rdata_o | rdata_i[c];
  end
  assign irq_o = |irq_i;
endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int ADDR_W  = 12,
  parameter int STRIDE  = 'h40,
  parameter int SPLIT   = 8,
  parameter int HI_WIN  = 'h800,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               rvalid_o,
  input  logic               fault_valid_i,
  input  logic [CTX_W-1:0]   fault_ctx_i,
  input  logic [FLT_W-1:0]   fault_type_i,
  input  logic [63:0]        fault_addr_i,
  input  logic [NUM_CTX-1:0] flush_done_i,
  output logic [NUM_CTX-1:0] flush_req_o,
  output logic [NUM_CTX-1:0] ctx_en_o,
  output logic               irq_o
);
  logic [NUM_CTX-1:0]       hit, irq_vec;
  logic [NUM_CTX-1:0][31:0] rd_vec;
  logic [31:0]              rd_mux;
  logic [31:0]              rdata_q;
  logic                     rvalid_q;
  reg_sel_e                 sel;

  xlat_addr_dec #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
    .SPLIT(SPLIT), .HI_WIN(HI_WIN)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .sel_o(sel)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    xlat_ctx_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (req_i && we_i && hit[c]),
      .sel_i       (sel),
      .wdata_i     (wdata_i),
      .rdata_o     (rd_vec[c]),
      .flt_i       (fault_valid_i && (fault_ctx_i == CTX_W'(c))),
      .flt_type_i  (fault_type_i),
      .flt_addr_i  (fault_addr_i),
      .flush_done_i(flush_done_i[c]),
      .en_o        (ctx_en_o[c]),
      .flush_o     (flush_req_o[c]),
      .irq_o       (irq_vec[c])
    );
  end

  xlat_collect #(.NUM_CTX(NUM_CTX)) u_col (
    .hit_i(hit), .rdata_i(rd_vec), .irq_i(irq_vec),
    .rdata_o(rd_mux), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/xlat_ctx_regbank_chk.sv
module xlat_ctx_regbank_chk #(
  parameter int NUM_CTX = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic               rvalid_o,
  input logic               fault_valid_i,
  input logic [NUM_CTX-1:0] flush_done_i,
  input logic [NUM_CTX-1:0] flush_req_o,
  input logic [NUM_CTX-1:0] ctx_en_o,
  input logic               irq_o
);
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);  // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);  // R1
  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(ctx_en_o));  // R3
  AST_IRQ_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !fault_valid_i && !(req_i && we_i)) |=> !irq_o);  // R8
  AST_IRQ_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(req_i && we_i)) |=> irq_o);  // R8

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_fl
    AST_FLUSH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_req_o[c] && !flush_done_i[c]) |=> flush_req_o[c]);  // R4
    AST_FLUSH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_done_i[c] && !(req_i && we_i)) |=> !flush_req_o[c]);  // R4
  end
endmodule

bind xlat_ctx_regbank xlat_ctx_regbank_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .rvalid_o(rvalid_o), .fault_valid_i(fault_valid_i),
  .flush_done_i(flush_done_i), .flush_req_o(flush_req_o),
  .ctx_en_o(ctx_en_o), .irq_o(irq_o)
);

// File: tb/xlat_ctx_regbank_test.sv
module xlat_ctx_regbank_test;
  localparam int CLK_P = 10;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        fv = 1'b0;
  logic [3:0]  fctx = '0;
  logic [4:0]  ftype = '0;
  logic [63:0] faddr = '0;
  logic [NC-1:0] fdone = '0;
  logic [NC-1:0] freq, cen;
  logic        irq;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  xlat_ctx_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .fault_valid_i(fv), .fault_ctx_i(fctx), .fault_type_i(ftype),
    .fault_addr_i(faddr), .flush_done_i(fdone), .flush_req_o(freq),
    .ctx_en_o(cen), .irq_o(irq)
  );

  function automatic logic [11:0] ra(input int c, input int off);
    return 12'((c < 8) ? c * 'h40 + off : 'h800 + (c - 8) * 'h40 + off);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as it emerges
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk(rdata, 32'hxxxx_xxxx, "R1 unexpected rvalid");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  task automatic flt(input int c, input logic [4:0] t, input logic [63:0] a);
    @(negedge clk); fv = 1; fctx = 4'(c); ftype = t; faddr = a;
    @(negedge clk); fv = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk({31'd0, irq}, 0, "R8 reset irq");
    chk(32'(freq), 0, "R4 reset flush");
    chk(32'(cen), 0, "R3 reset enable");
    rd(ra(0, 'h00), 0, "R1 reset ctrl read");

    // R9 plain storage, per context
    wr(ra(0, 'h08), 32'hA5A5_0001);
    wr(ra(15, 'h28), 32'h1234_5678);
    wr(ra(8, 'h14), 32'h0000_CAFE);
    wr(ra(8, 'h10), 32'hFFFF_0000);
    rd(ra(0, 'h08), 32'hA5A5_0001, "R9 cfg ctx0");
    rd(ra(15, 'h28), 32'h1234_5678, "R9 attr ctx15");
    rd(ra(8, 'h14), 32'h0000_CAFE, "R9 tbl hi ctx8");
    rd(ra(8, 'h10), 32'hFFFF_0000, "R9 tbl lo ctx8");
    rd(ra(7, 'h28), 0, "R9 attr ctx7 untouched");

    // R2 holes and relocated window
    wr(ra(0, 'h04), 32'hFFFF_FFFF);
    rd(ra(0, 'h04), 0, "R2 unmapped offset");
    rd(ra(0, 'h08), 32'hA5A5_0001, "R2 cfg intact after hole write");
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, 0, "R2 gap read");
    wr(12'h628, 32'h0BAD_0BAD);
    rd(ra(8, 'h28), 0, "R2 gap write no alias ctx8");
    rd(12'h828, 0, "R2 ctx8 attr raw addr");
    wr(12'h9E8, 32'h7777_0000);
    rd(ra(15, 'h28), 32'h7777_0000, "R2 ctx15 attr raw addr");

    // R3 control
    wr(ra(3, 'h00), 32'h5);
    chk(32'(cen), 32'h0008, "R3 enable ctx3");
    rd(ra(3, 'h00), 32'h5, "R3 ctrl readback");
    wr(ra(3, 'h00), 32'h0);
    chk(32'(cen), 0, "R3 disable ctx3");

    // R4 flush handshake
    wr(ra(8, 'h00), 32'h3);
    chk(32'(freq), 32'h0100, "R4 flush set");
    repeat (5) @(negedge clk);
    chk(32'(freq), 32'h0100, "R4 flush held");
    rd(ra(8, 'h00), 32'h3, "R4 flush reads 1");
    wr(ra(8, 'h00), 32'h1);
    rd(ra(8, 'h00), 32'h3, "R4 write 0 keeps flush");
    @(negedge clk); fdone[8] = 1;
    @(negedge clk); fdone[8] = 0;
    chk(32'(freq), 0, "R4 flush done");
    rd(ra(8, 'h00), 32'h1, "R4 flush cleared");

    // R5 fault capture
    wr(ra(2, 'h00), 32'h5);
    flt(2, 5'h02, 64'h0000_0012_3456_7000);
    chk({31'd0, irq}, 1, "R8 irq on fault");
    rd(ra(2, 'h20), 32'h2, "R5 status pf");
    rd(ra(2, 'h30), 32'h3456_7000, "R5 addr low");
    rd(ra(2, 'h34), 32'h0000_0012, "R5 addr high");

    // R6 no overwrite
    flt(2, 5'h10, 64'hFFFF_FFFF_0000_1111);
    rd(ra(2, 'h20), 32'h2, "R6 status kept");
    rd(ra(2, 'h30), 32'h3456_7000, "R6 addr kept");

    // R7 clear semantics
    wr(ra(2, 'h20), 32'h2);
    rd(ra(2, 'h20), 32'h2, "R7 write readback keeps");
    chk({31'd0, irq}, 1, "R7 irq kept");
    wr(ra(2, 'h20), 32'h0);
    chk({31'd0, irq}, 0, "R8 irq drops on clear");
    rd(ra(2, 'h20), 0, "R7 status cleared");
    rd(ra(2, 'h30), 0, "R7 addr low zero");
    rd(ra(2, 'h34), 0, "R7 addr high zero");
    flt(5, 5'h1F, 64'h0000_0000_0000_ABC0);
    rd(ra(5, 'h20), 32'h17, "R5 bit3 dropped");
    wr(ra(5, 'h20), 32'h01);
    rd(ra(5, 'h20), 32'h01, "R7 partial and");
    rd(ra(5, 'h30), 32'h0000_ABC0, "R7 addr kept while nonzero");

    // R8 enable gating
    flt(12, 5'h04, 64'h1);
    chk({31'd0, irq}, 0, "R8 irq masked");
    rd(ra(12, 'h20), 32'h4, "R5 abort ctx12");
    wr(ra(12, 'h00), 32'h4);
    chk({31'd0, irq}, 1, "R8 irq on enable");
    wr(ra(12, 'h00), 32'h0);
    chk({31'd0, irq}, 0, "R8 irq off on disable");

    repeat (4) @(negedge clk);
    chk(32'(exp_q.size()), 0, "R1 all reads returned");
    finish_run();
  end
endmodule